// File: doc/BRIEF.md
# Interrupt-Level Conditional Scratch Swap

This block holds one machine-mode scratch word for an interrupt controller that tracks nested interrupt levels. Software reaches it with the atomic read-write CSR instruction, naming the same general register (normally the stack pointer) as both source and destination. The exchange between that register and the scratch word only takes place when control crosses the boundary between application code (level zero) and interrupt-handler code (any non-zero level). Otherwise the access leaves both the scratch word and the general register as they were.

The trap logic supplies two levels: the level that was active before the trap, taken from the trap cause register, and the level that is active now, taken from the interrupt status register. A handler puts one access at its entry and one at its exit. On entry from application code this swaps in the handler stack. On return to application code it swaps the application stack back. Nested handlers see both levels non-zero, so no swap takes place. The block decodes the access in the same cycle and returns read data combinationally. The scratch word is updated on the next clock edge. Any access form other than the read-write instruction with non-zero register indices is flagged as illegal and has no effect.

Top module: `irq_scratch_swap`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, clears the scratch word to zero. The first exchange after reset returns zero on `accRdata`.
- R2: A legal access with `prevLevel` equal to zero and `curLevel` non-zero performs an exchange. `accRdata` shows the old scratch word in the access cycle, and the scratch word takes `accWdata` at the next edge.
- R3: A legal access with `prevLevel` non-zero and `curLevel` equal to zero performs the same exchange as R2.
- R4: A legal access with both levels equal to zero returns `accWdata` unchanged on `accRdata` and leaves the scratch word unmodified.
- R5: A legal access with both levels non-zero returns `accWdata` unchanged on `accRdata` and leaves the scratch word unmodified. Any non-zero value, for example 1 or 255, counts as handler level.
- R6: A valid access whose `accOp` differs from 3'b001 (the read-write form) raises `accIllegal`, returns zero on `accRdata` and leaves the scratch word unmodified. This covers the set 3'b010, clear 3'b011, immediate forms 3'b101/3'b110/3'b111, and the unused codes 3'b000 and 3'b100.
- R7: A read-write access (`accOp` = 3'b001) with `accRd` or `accRs1` equal to zero raises `accIllegal`, returns zero on `accRdata` and leaves the scratch word unmodified.
- R8: With `accValid` low, `accIllegal` is low, `accRdata` is zero and the scratch word is unmodified.
- R9: Exchanges in consecutive cycles chain: each one returns the write data of the exchange in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | A CSR access to the scratch register is presented this cycle |
| accOp | input | 3 | Access form: 3'b001 read-write, anything else unsupported |
| accRd | input | 5 | Destination register index |
| accRs1 | input | 5 | Source register index |
| accWdata | input | 32 | Value of the source register |
| prevLevel | input | 8 | Interrupt level before the trap (from the cause register) |
| curLevel | input | 8 | Interrupt level active now (from the status register) |
| accRdata | output | 32 | Value to write back to the destination register |
| accIllegal | output | 1 | The access form or an operand index is unsupported |

## Verification
During an exchange, the read of the old scratch word and the load of the new one fall in the same cycle. The returned data must still be the value from before that cycle's write. The bench provokes this by issuing exchanges on consecutive cycles with alternating level pairs, so that each load meets the next read at one clock edge. A scoreboard model that updates its own scratch copy only after computing the expected read data judges every cycle. Same-domain and illegal accesses sit between exchanges, and the next exchange's returned value shows that they left the word alone.

// File: rtl/irq_swap_pkg.sv
package irq_swap_pkg;

  localparam int XLEN    = 32;
  localparam int LVL_W   = 8;
  localparam int IDX_W   = 5;
  localparam int OP_W    = 3;

  // access form codes
  localparam logic [OP_W-1:0] OP_RW  = 3'b001;
  localparam logic [OP_W-1:0] OP_RS  = 3'b010;
  localparam logic [OP_W-1:0] OP_RC  = 3'b011;
  localparam logic [OP_W-1:0] OP_RWI = 3'b101;
  localparam logic [OP_W-1:0] OP_RSI = 3'b110;
  localparam logic [OP_W-1:0] OP_RCI = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture write data into scratch
    logic readOld;  // drive old scratch onto read data
    logic echo;     // drive write data back unchanged
    logic illegal;  // unsupported form
  } swap_stb_t;

endpackage

// File: rtl/irq_swap_ctrl.sv
module irq_swap_ctrl
  import irq_swap_pkg::*;
#(
  parameter int LvlW = LVL_W,
  parameter int IdxW = IDX_W,
  parameter int OpW  = OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accValid,
  input  logic [OpW-1:0]  accOp,
  input  logic [IdxW-1:0] accRd,
  input  logic [IdxW-1:0] accRs1,
  input  logic [LvlW-1:0] prevLevel,
  input  logic [LvlW-1:0] curLevel,
  output swap_stb_t       stb
);

  localparam int NumLvl = 2;

  logic [NumLvl-1:0][LvlW-1:0] lvlVec;
  logic [NumLvl-1:0]           lvlIsApp;

  assign lvlVec[0] = prevLevel;
  assign lvlVec[1] = curLevel;

  // one zero detector per level source
  for (genvar g = 0; g < NumLvl; g++) begin : g_lvl
    assign lvlIsApp[g] = ~|lvlVec[g];
  end

  logic formOk;
  logic regsOk;
  logic legalAcc;
  logic crossDomain;

  always_comb begin
    formOk      = (accOp == OP_RW);
    regsOk      = (|accRd) && (|accRs1);
    legalAcc    = accValid && formOk && regsOk;
    crossDomain = lvlIsApp[0] ^ lvlIsApp[1];

    stb         = '0;
    stb.illegal = accValid && !legalAcc;
    if (legalAcc) begin
      if (crossDomain) begin
        stb.load    = 1'b1;
        stb.readOld = 1'b1;
      end else begin
        stb.echo    = 1'b1;
      end
    end
  end

  // R6
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    stb.illegal |-> !stb.load && !stb.readOld && !stb.echo);

  // R4
  same_domain_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (accValid && ((prevLevel == '0) == (curLevel == '0))) |-> !stb.load);

  // R2
  cross_domain_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (accValid && accOp == OP_RW && accRd != '0 && accRs1 != '0 &&
     ((prevLevel == '0) != (curLevel == '0))) |-> (stb.load && stb.readOld));

  // R8
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !accValid |-> (stb == '0));

endmodule

// File: rtl/irq_swap_dp.sv
module irq_swap_dp
  import irq_swap_pkg::*;
#(
  parameter int XLen = XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  swap_stb_t       stb,
  input  logic [XLen-1:0] wdata,
  output logic [XLen-1:0] rdata
);

  logic [XLen-1:0] scratchQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      scratchQ <= '0;
    end else if (stb.load) begin
      scratchQ <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (stb.readOld) begin
      rdata = scratchQ;
    end else if (stb.echo) begin
      rdata = wdata;
    end
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> $stable(scratchQ));

  // R9
  load_lands_chk: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> (scratchQ == $past(wdata)));

  // R2
  read_mux_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.readOld, stb.echo}));

endmodule

// File: rtl/irq_scratch_swap.sv
module irq_scratch_swap
  import irq_swap_pkg::*;
#(
  parameter int XLen = XLEN,
  parameter int LvlW = LVL_W,
  parameter int IdxW = IDX_W,
  parameter int OpW  = OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accValid,
  input  logic [OpW-1:0]  accOp,
  input  logic [IdxW-1:0] accRd,
  input  logic [IdxW-1:0] accRs1,
  input  logic [XLen-1:0] accWdata,
  input  logic [LvlW-1:0] prevLevel,
  input  logic [LvlW-1:0] curLevel,
  output logic [XLen-1:0] accRdata,
  output logic            accIllegal
);

  swap_stb_t stb;

  irq_swap_ctrl #(
    .LvlW (LvlW),
    .IdxW (IdxW),
    .OpW  (OpW)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accValid  (accValid),
    .accOp     (accOp),
    .accRd     (accRd),
    .accRs1    (accRs1),
    .prevLevel (prevLevel),
    .curLevel  (curLevel),
    .stb       (stb)
  );

  irq_swap_dp #(
    .XLen (XLen)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .wdata (accWdata),
    .rdata (accRdata)
  );

  assign accIllegal = stb.illegal;

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !accValid |-> (!accIllegal && accRdata == '0));

  // R7
  illegal_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    accIllegal |-> (accRdata == '0));

endmodule

// File: tb/irq_scratch_swap_bench.sv
module irq_scratch_swap_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accValid = 1'b0;
  logic [2:0]  accOp = 3'b000;
  logic [4:0]  accRd = '0;
  logic [4:0]  accRs1 = '0;
  logic [31:0] accWdata = '0;
  logic [7:0]  prevLevel = '0;
  logic [7:0]  curLevel = '0;
  logic [31:0] accRdata;
  logic        accIllegal;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_scratch_swap u_irq_scratch_swap (
    .clk        (clk),
    .rst        (rst),
    .accValid   (accValid),
    .accOp      (accOp),
    .accRd      (accRd),
    .accRs1     (accRs1),
    .accWdata   (accWdata),
    .prevLevel  (prevLevel),
    .curLevel   (curLevel),
    .accRdata   (accRdata),
    .accIllegal (accIllegal)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] modelScratch = '0;
  int          vecCount = 0;
  int          missCount = 0;
  bit          finished = 1'b0;

  // driver: one vector per cycle, expected result computed from requirements
  task automatic drive(input logic v, input logic [2:0] op, input logic [4:0] rd,
                       input logic [4:0] rs1, input logic [31:0] wd,
                       input logic [7:0] pl, input logic [7:0] cl, input string tag);
    exp_t e;
    logic ill;
    logic sw;
    @(posedge clk);
    #1;
    accValid = v; accOp = op; accRd = rd; accRs1 = rs1;
    accWdata = wd; prevLevel = pl; curLevel = cl;
    ill = v && (op != 3'b001 || rd == 5'd0 || rs1 == 5'd0);
    sw  = v && !ill && ((pl == 8'd0) != (cl == 8'd0));
    e.ill   = ill;
    e.tag   = tag;
    e.rdata = (!v || ill) ? 32'd0 : (sw ? modelScratch : wd);
    if (sw) modelScratch = wd;
    expQ.push_back(e);
  endtask

  task automatic swapAcc(input logic [31:0] wd, input logic [7:0] pl,
                         input logic [7:0] cl, input string tag);
    drive(1'b1, 3'b001, 5'd2, 5'd2, wd, pl, cl, tag);
  endtask

  task automatic doReset();
    @(posedge clk);
    #1;
    rst = 1'b1; accValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    modelScratch = '0;
  endtask

  // monitor: compares mid-cycle, before the next edge updates the register
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        vecCount++;
        if (accRdata !== e.rdata || accIllegal !== e.ill) begin
          missCount++;
          $display("FAIL %s: rdata=%h illegal=%b expected rdata=%h illegal=%b",
                   e.tag, accRdata, accIllegal, e.rdata, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      missCount++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    doReset();
    // R8 idle
    drive(1'b0, 3'b001, 5'd2, 5'd2, 32'hDEAD_BEEF, 8'd0, 8'd3, "R8");
    // R1 first exchange after reset returns zero; R2 entry
    swapAcc(32'h1111_0000, 8'd0, 8'd3, "R1");
    // R3 exit
    swapAcc(32'h2222_0000, 8'd3, 8'd0, "R3");
    // R4 both zero
    swapAcc(32'h3333_0000, 8'd0, 8'd0, "R4");
    // R5 both non-zero, extremes
    swapAcc(32'h4444_0000, 8'd1, 8'd255, "R5");
    swapAcc(32'h4444_0001, 8'd255, 8'd1, "R5");
    // R2 shows scratch untouched by R4/R5
    swapAcc(32'h5555_0000, 8'd0, 8'd255, "R2");
    // R6 every unsupported form
    for (int k = 0; k < 8; k++) begin
      if (k != 1) drive(1'b1, 3'(k), 5'd2, 5'd2, 32'hBAD0_0000 + 32'(k), 8'd0, 8'd1, "R6");
    end
    // R7 x0 operands
    drive(1'b1, 3'b001, 5'd0, 5'd2, 32'hBAD1_0000, 8'd0, 8'd1, "R7");
    drive(1'b1, 3'b001, 5'd2, 5'd0, 32'hBAD1_0001, 8'd1, 8'd0, "R7");
    drive(1'b1, 3'b001, 5'd0, 5'd0, 32'hBAD1_0002, 8'd0, 8'd1, "R7");
    // R8 idle with cross-domain levels
    drive(1'b0, 3'b001, 5'd2, 5'd2, 32'hBAD2_0000, 8'd0, 8'd1, "R8");
    // R2 returns value from before R6/R7/R8 stimulus
    swapAcc(32'h6666_0000, 8'd0, 8'd7, "R2");
    // R9 back-to-back exchanges
    for (int k = 0; k < 6; k++) begin
      if (k % 2 == 0) swapAcc(32'h7000_0000 + 32'(k), 8'd0, 8'(k + 1), "R9");
      else            swapAcc(32'h7000_0000 + 32'(k), 8'(k + 16), 8'd0, "R9");
    end
    // mixed stream
    swapAcc(32'h8888_0000, 8'd2, 8'd3, "R5");
    swapAcc(32'h8888_0001, 8'd0, 8'd2, "R2");
    drive(1'b1, 3'b010, 5'd2, 5'd2, 32'h8888_0002, 8'd2, 8'd0, "R6");
    swapAcc(32'h8888_0003, 8'd2, 8'd0, "R3");
    // R1 reset mid-run clears scratch
    drive(1'b0, 3'b000, 5'd0, 5'd0, 32'd0, 8'd0, 8'd0, "R8");
    @(negedge clk);
    doReset();
    swapAcc(32'h9999_0000, 8'd4, 8'd0, "R1");
    swapAcc(32'h9999_0001, 8'd0, 8'd4, "R9");
    drive(1'b0, 3'b000, 5'd0, 5'd0, 32'd0, 8'd0, 8'd0, "R8");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule